// File: doc/BRIEF.md
# Write-Guarded Configuration Register Bank

This block keeps a few system configuration registers behind a plain register bus (write strobe, address, write data, combinational read data). Every bit carries one of four write policies, given as per-register mask parameters: free, window-limited (one write, only in the startup window), write-once (one write, at any time, in any mode), or clear-protected (cleared to zero only once and only in the startup window, set to one at any time). Blocked parts of a write are dropped without any indication.

A small state machine measures the startup window. Synchronous reset puts it in `ST_OPEN` with the counter at zero. Transition `open_count`: each clock in `ST_OPEN` adds one to the counter. Transition `window_expire`: in `ST_OPEN` with the counter at WINDOW-1, the next state is `ST_CLOSED` and the counter reaches WINDOW. Transition `closed_hold`: `ST_CLOSED` stays put with the counter held at WINDOW, so the window never opens again before the next reset. Two strap inputs are captured on every clock edge while reset is high into a special-mode bit and an alternate-mode bit. Special mode lifts the window and single-write limits on window-limited and clear-protected bits but not on write-once bits.

Top module: `cfg_guard_bank`

## Requirements
- R1: After reset, the registers read back their reset values: register 0 = 0x00, register 1 = 0x00, register 2 = 0x1F, register 3 = 0x00; read data follows the address in the same cycle.
- R2: `special_o` and `alt_mode_o` equal `strap_spec_i` and `strap_alt_i` as sampled while reset was high; strap changes after reset release have no effect.
- R3: With special mode 0, the first write to a register sets its window-limited bits (register 0 mask 0x37) when it lands on any of the first WINDOW (64) clock edges after reset release, including edge 64.
- R4: With special mode 0, window-limited bits ignore a second write, and ignore any write landing on edge 65 or later.
- R5: Register 1 is write-once in every bit: after the first write, even one equal to its reset value, later writes are ignored.
- R6: Register 3 bits 5..2 (mask 0x3C) are write-once; its bits 7, 6, 1 and 0 stay freely writable.
- R7: Register 2 bits 4..0 (mask 0x1F) may be cleared only by the first write and only inside the window when special mode is 0; writing ones to them is accepted at any time.
- R8: Bits outside every policy mask take the written value on every write, inside or after the window.
- R9: The window does not reopen: with special mode 0, window-limited and clear-protected bits stay blocked at any time after edge 64 until the next reset.
- R10: With special mode 1, window-limited and clear-protected bits accept every write at any time; write-once bits still lock after their first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strap_spec_i | input | 1 | Strap sampled during reset into the special-mode bit |
| strap_alt_i | input | 1 | Strap sampled during reset into the alternate-mode bit |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | AW (2) | Register index |
| wdata_i | input | DW (8) | Write data |
| rdata_o | output | DW (8) | Contents of the addressed register |
| special_o | output | 1 | Latched special-mode bit |
| alt_mode_o | output | 1 | Latched alternate-mode bit |

## Verification
A write that is driven on a falling edge takes effect at the following rising edge, and read data is combinational, so every readback is due one settle delay after the address is set on the falling edge that follows the write. The bench drives all stimulus on falling edges and counts rising edges from reset release, which places boundary writes exactly on edge 64 and edge 65. The strap outputs are due on the first edge with reset high, and are compared only after release, once the straps have been changed and two more edges have passed.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_CLOSED = 1'b1
    } win_state_e;

endpackage

// File: rtl/cfg_window_fsm.sv
module cfg_window_fsm
    import cfg_guard_pkg::*;
#(
    parameter int WINDOW = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic open_o
);
    localparam int CW = $clog2(WINDOW + 1);

    win_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: open_count, window_expire, closed_hold
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CW'(WINDOW - 1)) state_d = ST_CLOSED;
            end
            ST_CLOSED: begin
                cnt_d = cnt_q;
            end
        endcase
    end

    // outputs
    always_comb begin
        open_o = (state_q == ST_OPEN);
    end

    a_r9_closed_stays: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CLOSED) |=> (state_q == ST_CLOSED));

    a_r9_count_saturates: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CLOSED) |-> (cnt_q == CW'(WINDOW)));

    a_r3_open_counts: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_OPEN) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic strap_spec_i,
    input  logic strap_alt_i,
    output logic special_o,
    output logic alt_mode_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            special_o  <= strap_spec_i;
            alt_mode_o <= strap_alt_i;
        end
    end

    a_r2_mode_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> ($stable(special_o) && $stable(alt_mode_o)));

endmodule

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] RST_VAL   = '0,
    parameter logic [DW-1:0] WIN_MASK  = '0,
    parameter logic [DW-1:0] ONCE_MASK = '0,
    parameter logic [DW-1:0] CLR_MASK  = '0
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          open_i,
    input  logic          special_i,
    output logic [DW-1:0] q_o
);
    localparam logic [DW-1:0] FREE_MASK = ~(WIN_MASK | ONCE_MASK | CLR_MASK);

    logic          win_done_q, once_done_q, clr_done_q;
    logic          win_ok, clr_ok, once_ok;
    logic [DW-1:0] nxt;

    always_comb begin
        win_ok  = special_i | (open_i & ~win_done_q);
        clr_ok  = special_i | (open_i & ~clr_done_q);
        once_ok = ~once_done_q;
        nxt = (wdata_i & FREE_MASK)
            | ((win_ok  ? wdata_i : q_o) & WIN_MASK)
            | ((once_ok ? wdata_i : q_o) & ONCE_MASK)
            | ((clr_ok  ? wdata_i : (q_o | wdata_i)) & CLR_MASK);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o         <= RST_VAL;
            win_done_q  <= 1'b0;
            once_done_q <= 1'b0;
            clr_done_q  <= 1'b0;
        end else if (we_i) begin
            q_o         <= nxt;
            once_done_q <= 1'b1;
            if (win_ok) win_done_q <= 1'b1;
            if (clr_ok) clr_done_q <= 1'b1;
        end
    end

    a_r4_window_bits_locked: assert property (@(posedge clk_i) disable iff (rst_i)
        (!special_i && (!open_i || win_done_q)) |=> ((q_o & WIN_MASK) == ($past(q_o) & WIN_MASK)));

    a_r5_once_bits_locked: assert property (@(posedge clk_i) disable iff (rst_i)
        once_done_q |=> ((q_o & ONCE_MASK) == ($past(q_o) & ONCE_MASK)));

    a_r7_no_late_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (!special_i && (!open_i || clr_done_q)) |=> (((q_o & $past(q_o)) & CLR_MASK) == ($past(q_o) & CLR_MASK)));

    a_r8_quiet_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(q_o));

endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank #(
    parameter int                   NREG      = 4,
    parameter int                   DW        = 8,
    parameter int                   WINDOW    = 64,
    parameter int                   AW        = (NREG > 1) ? $clog2(NREG) : 1,
    parameter logic [NREG*DW-1:0]   P_RST     = {8'h00, 8'h1F, 8'h00, 8'h00},
    parameter logic [NREG*DW-1:0]   P_WIN     = {8'h00, 8'h00, 8'h00, 8'h37},
    parameter logic [NREG*DW-1:0]   P_ONCE    = {8'h3C, 8'h00, 8'hFF, 8'h00},
    parameter logic [NREG*DW-1:0]   P_CLR     = {8'h00, 8'h1F, 8'h00, 8'h00}
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          strap_spec_i,
    input  logic          strap_alt_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          special_o,
    output logic          alt_mode_o
);
    logic          open_w;
    logic [DW-1:0] regs [NREG];

    cfg_window_fsm #(.WINDOW(WINDOW)) i_fsm (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .open_o (open_w)
    );

    cfg_mode_latch i_mode (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .strap_spec_i (strap_spec_i),
        .strap_alt_i  (strap_alt_i),
        .special_o    (special_o),
        .alt_mode_o   (alt_mode_o)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_slot
        cfg_reg_slot #(
            .DW        (DW),
            .RST_VAL   (P_RST[r*DW +: DW]),
            .WIN_MASK  (P_WIN[r*DW +: DW]),
            .ONCE_MASK (P_ONCE[r*DW +: DW]),
            .CLR_MASK  (P_CLR[r*DW +: DW])
        ) i_slot (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .we_i      (wr_en_i && (addr_i == AW'(r))),
            .wdata_i   (wdata_i),
            .open_i    (open_w),
            .special_i (special_o),
            .q_o       (regs[r])
        );
    end

    always_comb begin
        rdata_o = regs[addr_i];
    end

endmodule

// File: tb/test_cfg_guard_bank.sv
`timescale 1ns/1ps
module test_cfg_guard_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       s_spec = 1'b0;
    logic       s_alt = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       special, alt_mode;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    cfg_guard_bank i_cfg_guard_bank (
        .clk_i        (clk),
        .rst_i        (rst),
        .strap_spec_i (s_spec),
        .strap_alt_i  (s_alt),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .special_o    (special),
        .alt_mode_o   (alt_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic sp, input logic al);
        @(negedge clk);
        rst = 1'b1; s_spec = sp; s_alt = al;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_and_straps;
        do_reset(1'b0, 1'b1);
        rd(2'd0, 8'h00, "R1 reg0 reset");
        rd(2'd1, 8'h00, "R1 reg1 reset");
        rd(2'd2, 8'h1F, "R1 reg2 reset");
        rd(2'd3, 8'h00, "R1 reg3 reset");
        chk("R2 special latched", {7'd0, special}, 8'd0);
        chk("R2 alt latched", {7'd0, alt_mode}, 8'd1);
        s_spec = 1'b1; s_alt = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 special ignores strap", {7'd0, special}, 8'd0);
        chk("R2 alt ignores strap", {7'd0, alt_mode}, 8'd1);
    endtask

    task automatic t_in_window;
        wr(2'd0, 8'hFF); rd(2'd0, 8'hFF, "R3 window bits first write");
        wr(2'd0, 8'h00); rd(2'd0, 8'h37, "R4 second write blocked / R8 free bits");
        wr(2'd1, 8'h00); rd(2'd1, 8'h00, "R5 write of reset value");
        wr(2'd1, 8'h77); rd(2'd1, 8'h00, "R5 once lock");
        wr(2'd3, 8'hFF); rd(2'd3, 8'hFF, "R6 first write");
        wr(2'd3, 8'h00); rd(2'd3, 8'h3C, "R6 partial once");
        wr(2'd2, 8'h10); rd(2'd2, 8'h10, "R7 clear in window");
        wr(2'd2, 8'h00); rd(2'd2, 8'h10, "R7 second clear blocked");
        wr(2'd2, 8'h03); rd(2'd2, 8'h13, "R7 set allowed");
        repeat (70) @(negedge clk);
        wr(2'd2, 8'h00); rd(2'd2, 8'h13, "R7 clear after window");
        wr(2'd0, 8'hC8); rd(2'd0, 8'hFF, "R8 free bits after window");
    endtask

    task automatic t_boundary;
        do_reset(1'b0, 1'b0);
        repeat (63) @(negedge clk);
        wr(2'd0, 8'hFF); rd(2'd0, 8'hFF, "R3 write on edge 64");
        do_reset(1'b0, 1'b0);
        repeat (64) @(negedge clk);
        wr(2'd0, 8'hFF); rd(2'd0, 8'hC8, "R4 write on edge 65");
        wr(2'd2, 8'h00); rd(2'd2, 8'h1F, "R7 first clear after window");
    endtask

    task automatic t_no_reopen;
        for (int i = 0; i < 6; i++) begin
            repeat (37) @(negedge clk);
            wr(2'd0, 8'h37); rd(2'd0, 8'h00, "R9 window bits stay blocked");
            wr(2'd2, 8'h00); rd(2'd2, 8'h1F, "R9 clear bits stay blocked");
        end
    endtask

    task automatic t_special;
        do_reset(1'b1, 1'b0);
        chk("R2 special set", {7'd0, special}, 8'd1);
        chk("R2 alt clear", {7'd0, alt_mode}, 8'd0);
        repeat (100) @(negedge clk);
        wr(2'd0, 8'hFF); rd(2'd0, 8'hFF, "R10 late window write");
        wr(2'd0, 8'h00); rd(2'd0, 8'h00, "R10 repeated window write");
        wr(2'd2, 8'h00); rd(2'd2, 8'h00, "R10 late clear");
        wr(2'd2, 8'h05); rd(2'd2, 8'h05, "R10 set");
        wr(2'd2, 8'h00); rd(2'd2, 8'h00, "R10 repeated clear");
        wr(2'd1, 8'h11); rd(2'd1, 8'h11, "R10 once first");
        wr(2'd1, 8'h22); rd(2'd1, 8'h11, "R10 once still locks");
    endtask

    initial begin
        t_reset_and_straps();
        t_in_window();
        t_boundary();
        t_no_reopen();
        t_special();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule